// File: doc/BRIEF.md
# In-Flight Block Window Controller

This controller keeps the bookkeeping for whole instruction blocks that are fetched, executed and retired as indivisible units. When a block is fetched, the controller grants it a frame and records how many outputs the block declares. Completion events tagged with a frame id are counted against that number. Once a frame has received all of its outputs and is the oldest frame of its thread, it retires as a whole. Any number of younger blocks may be executing at the same time, and they may finish in any order. None of their results can retire ahead of an older block.

A misprediction names one frame. That frame is discarded together with every frame of the same thread that was fetched after it. Older frames are kept, and the next fetch for that thread reuses the discarded frame. A mode input divides the eight frames in one of two ways. In single-thread mode, one thread uses all eight frames as a ring. In four-thread mode, each thread owns a private ring of two frames. The mode may only change while the controller is held in reset.

Top module: `block_window`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, no frame is in use: commit_vld and flush_vld are zero, and a fetch request from thread 0 is granted frame 0.
- R2: Fetch grants are combinational, and each grant names the next frame of the thread's ring. In single-thread mode that is the frame after the youngest one in use, counting 0 to 7 and wrapping, with the oldest frame as the starting point.
- R3: fetch_gnt stays low while the requesting thread already holds its full share of frames: eight in single-thread mode, two in four-thread mode.
- R4: A frame becomes complete when the number of done events it has received equals the count declared at its fetch. The following done events change nothing: events that name a frame not in use, and events that arrive after the frame is complete.
- R5: A frame retires only when it is complete and is the oldest frame of its thread. Its retirement shows as commit_vld[t] together with its frame id in commit_frame, one cycle after the last edge at which it was younger or incomplete.
- R6: Each thread retires at most one frame per cycle. Different threads can retire in the same cycle.
- R7: A misprediction on frame F that is in use raises flush_vld in the next cycle. flush_mask is then set for F and for every younger frame of the same thread, and for no other frame. Older frames stay in use, and the thread's next grant is F.
- R8: A misprediction naming a frame that is not in use has no effect. In the cycle of a valid misprediction, the affected thread gets no grant and retires nothing.
- R9: A block that declares zero outputs is complete at once, and it retires as soon as it becomes the oldest frame of its thread.
- R10: When mt_mode is 1, thread t owns frames 2t and 2t+1. When mt_mode is 0, requests from a thread other than 0 are refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mt_mode | input | 1 | 0: single thread on eight frames; 1: four threads with two frames each |
| fetch_req | input | 1 | Fetch request for a new block |
| fetch_tid | input | 2 | Requesting thread |
| fetch_nout | input | 8 | Number of outputs the block declares |
| fetch_gnt | output | 1 | Request granted in this cycle |
| fetch_frame | output | 3 | Frame assigned to the granted block |
| done_vld | input | 1 | One block output has completed |
| done_frame | input | 3 | Frame of that output |
| mis_vld | input | 1 | Misprediction event |
| mis_frame | input | 3 | Frame that was mispredicted |
| commit_vld | output | 4 | Per-thread retirement pulse |
| commit_frame | output | 12 | Per-thread retired frame id, 3 bits per thread, thread 0 in the low bits |
| flush_vld | output | 1 | Flush pulse |
| flush_mask | output | 8 | Frames discarded by the flush |

## Verification
The assertions assume that mt_mode only changes while reset is asserted. They also assume at most one done event and one misprediction per cycle, each carrying a frame id below eight. The stimulus keeps to these conditions: mt_mode is only changed during reset, and every input is driven from a single task that drives one event of each kind per cycle. The test sequences target the cases where decisions collide: a misprediction in the same cycle as a fetch request, a block that completes out of order, done and misprediction events that name free frames, and two threads retiring in the same cycle.

// File: rtl/block_window.sv
module block_window #(
  parameter int FRAMES  = 8,
  parameter int THREADS = 4,
  parameter int OUT_W   = 8,
  localparam int FID_W  = $clog2(FRAMES),
  localparam int TID_W  = $clog2(THREADS),
  localparam int FPT    = FRAMES / THREADS,
  localparam int FPT_W  = $clog2(FPT)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       mt_mode,
  input  logic                       fetch_req,
  input  logic [TID_W-1:0]           fetch_tid,
  input  logic [OUT_W-1:0]           fetch_nout,
  output logic                       fetch_gnt,
  output logic [FID_W-1:0]           fetch_frame,
  input  logic                       done_vld,
  input  logic [FID_W-1:0]           done_frame,
  input  logic                       mis_vld,
  input  logic [FID_W-1:0]           mis_frame,
  output logic [THREADS-1:0]         commit_vld,
  output logic [THREADS*FID_W-1:0]   commit_frame,
  output logic                       flush_vld,
  output logic [FRAMES-1:0]          flush_mask
);

  logic [FRAMES-1:0] busy;
  logic [OUT_W-1:0]  decl [FRAMES];
  logic [OUT_W-1:0]  got  [FRAMES];
  logic [FID_W-1:0]  head [THREADS];
  logic [FID_W:0]    occ  [THREADS];

  wire [FID_W-1:0] msk = mt_mode ? FID_W'(FPT - 1) : FID_W'(FRAMES - 1);
  wire [FID_W:0]   cap = mt_mode ? (FID_W+1)'(FPT) : (FID_W+1)'(FRAMES);

  function automatic logic [TID_W-1:0] owner(input logic [FID_W-1:0] f);
    return mt_mode ? TID_W'(f >> FPT_W) : '0;
  endfunction

  function automatic logic [FID_W-1:0] base(input logic [TID_W-1:0] t);
    return mt_mode ? (FID_W'(t) << FPT_W) : '0;
  endfunction

  logic                mis_ok;
  logic [TID_W-1:0]    mis_tid;
  logic [FID_W-1:0]    mis_age;
  logic [FRAMES-1:0]   kill, ret_mask;
  logic [THREADS-1:0]  retire;
  logic [FID_W-1:0]    hf [THREADS];

  always_comb begin
    mis_ok  = mis_vld && busy[mis_frame];
    mis_tid = owner(mis_frame);
    mis_age = ((mis_frame & msk) - head[mis_tid]) & msk;
    for (int f = 0; f < FRAMES; f++)
      kill[f] = mis_ok && busy[f] && owner(FID_W'(f)) == mis_tid &&
                (((FID_W'(f) & msk) - head[mis_tid]) & msk) >= mis_age;
    ret_mask = '0;
    for (int t = 0; t < THREADS; t++) begin
      hf[t]     = base(TID_W'(t)) + head[t];
      retire[t] = occ[t] != '0 && got[hf[t]] == decl[hf[t]] &&
                  !(mis_ok && mis_tid == TID_W'(t));
      if (retire[t]) ret_mask[hf[t]] = 1'b1;
    end
  end

  wire tid_ok = mt_mode || fetch_tid == '0;
  assign fetch_frame = base(fetch_tid) +
                       ((head[fetch_tid] + occ[fetch_tid][FID_W-1:0]) & msk);
  assign fetch_gnt = fetch_req && tid_ok && occ[fetch_tid] < cap &&
                     !(mis_ok && mis_tid == fetch_tid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy         <= '0;
      commit_vld   <= '0;
      commit_frame <= '0;
      flush_vld    <= 1'b0;
      flush_mask   <= '0;
      for (int f = 0; f < FRAMES; f++) begin
        decl[f] <= '0;
        got[f]  <= '0;
      end
      for (int t = 0; t < THREADS; t++) begin
        head[t] <= '0;
        occ[t]  <= '0;
      end
    end else begin
      flush_vld  <= mis_ok;
      flush_mask <= kill;
      commit_vld <= retire;
      for (int t = 0; t < THREADS; t++) begin
        commit_frame[t*FID_W +: FID_W] <= hf[t];
        if (mis_ok && mis_tid == TID_W'(t))
          occ[t] <= {1'b0, mis_age};
        else
          occ[t] <= occ[t] - (FID_W+1)'(retire[t]) +
                    (FID_W+1)'(fetch_gnt && fetch_tid == TID_W'(t));
        if (retire[t]) head[t] <= (head[t] + 1'b1) & msk;
      end
      for (int f = 0; f < FRAMES; f++) begin
        if (kill[f] || ret_mask[f])
          busy[f] <= 1'b0;
        else if (done_vld && done_frame == FID_W'(f) && busy[f] && got[f] != decl[f])
          got[f] <= got[f] + 1'b1;
        if (fetch_gnt && fetch_frame == FID_W'(f)) begin
          busy[f] <= 1'b1;
          decl[f] <= fetch_nout;
          got[f]  <= '0;
        end
      end
    end
  end

  logic [FID_W+TID_W+1:0] occ_sum;
  always_comb begin
    occ_sum = '0;
    for (int t = 0; t < THREADS; t++) occ_sum = occ_sum + (FID_W+TID_W+2)'(occ[t]);
  end

  assert_gnt_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_gnt |-> !busy[fetch_frame]);

  assert_occ_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    occ_sum == (FID_W+TID_W+2)'($countones(busy)));

  assert_flush_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_vld |-> (flush_mask != '0 && (busy & flush_mask) == '0));

  assert_bad_mis_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mis_vld && !busy[mis_frame]) |=> !flush_vld);

  assert_single_thread_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mt_mode |-> commit_vld[THREADS-1:1] == '0);

  for (genvar t = 0; t < THREADS; t++) begin : g_chk
    assert_commit_frees_R5: assert property (@(posedge clk) disable iff (!rst_n)
      commit_vld[t] |-> !busy[commit_frame[t*FID_W +: FID_W]]);
  end

  for (genvar f = 0; f < FRAMES; f++) begin : g_cnt
    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy[f] |-> got[f] <= decl[f]);
  end

endmodule

// File: tb/sim_block_window.sv
module sim_block_window;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mt_mode;
  logic        fetch_req;
  logic [1:0]  fetch_tid;
  logic [7:0]  fetch_nout;
  logic        fetch_gnt;
  logic [2:0]  fetch_frame;
  logic        done_vld;
  logic [2:0]  done_frame;
  logic        mis_vld;
  logic [2:0]  mis_frame;
  logic [3:0]  commit_vld;
  logic [11:0] commit_frame;
  logic        flush_vld;
  logic [7:0]  flush_mask;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  block_window u0 (
    .clk(clk), .rst_n(rst_n), .mt_mode(mt_mode),
    .fetch_req(fetch_req), .fetch_tid(fetch_tid), .fetch_nout(fetch_nout),
    .fetch_gnt(fetch_gnt), .fetch_frame(fetch_frame),
    .done_vld(done_vld), .done_frame(done_frame),
    .mis_vld(mis_vld), .mis_frame(mis_frame),
    .commit_vld(commit_vld), .commit_frame(commit_frame),
    .flush_vld(flush_vld), .flush_mask(flush_mask)
  );

  // fields: req tid nout dv df mv mf | gnt frame cv cf fv mask
  localparam logic [35:0] VEC [20] = '{
    {1'b1,2'd0,8'd2, 1'b0,3'd0, 1'b0,3'd0, 1'b1,3'd0, 1'b0,3'd0, 1'b0,8'h00},
    {1'b1,2'd0,8'd1, 1'b0,3'd0, 1'b0,3'd0, 1'b1,3'd1, 1'b0,3'd0, 1'b0,8'h00},
    {1'b1,2'd0,8'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b1,3'd2, 1'b0,3'd0, 1'b0,8'h00},
    {1'b0,2'd0,8'd0, 1'b1,3'd1, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0,8'h00},
    {1'b0,2'd0,8'd0, 1'b1,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0,8'h00},
    {1'b0,2'd0,8'd0, 1'b1,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0,8'h00},
    {1'b0,2'd0,8'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b1,3'd0, 1'b0,8'h00},
    {1'b0,2'd0,8'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b1,3'd1, 1'b0,8'h00},
    {1'b0,2'd0,8'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b1,3'd2, 1'b0,8'h00},
    {1'b1,2'd0,8'd3, 1'b0,3'd0, 1'b0,3'd0, 1'b1,3'd3, 1'b0,3'd0, 1'b0,8'h00},
    {1'b1,2'd0,8'd1, 1'b0,3'd0, 1'b0,3'd0, 1'b1,3'd4, 1'b0,3'd0, 1'b0,8'h00},
    {1'b1,2'd0,8'd1, 1'b0,3'd0, 1'b0,3'd0, 1'b1,3'd5, 1'b0,3'd0, 1'b0,8'h00},
    {1'b0,2'd0,8'd0, 1'b1,3'd7, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0,8'h00},
    {1'b1,2'd0,8'd1, 1'b0,3'd0, 1'b1,3'd4, 1'b0,3'd0, 1'b0,3'd0, 1'b1,8'h30},
    {1'b1,2'd0,8'd1, 1'b0,3'd0, 1'b0,3'd0, 1'b1,3'd4, 1'b0,3'd0, 1'b0,8'h00},
    {1'b0,2'd0,8'd0, 1'b1,3'd3, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0,8'h00},
    {1'b0,2'd0,8'd0, 1'b1,3'd3, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0,8'h00},
    {1'b0,2'd0,8'd0, 1'b1,3'd3, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0,8'h00},
    {1'b0,2'd0,8'd0, 1'b1,3'd3, 1'b0,3'd0, 1'b0,3'd0, 1'b1,3'd3, 1'b0,8'h00},
    {1'b0,2'd0,8'd0, 1'b0,3'd0, 1'b1,3'd3, 1'b0,3'd0, 1'b0,3'd0, 1'b0,8'h00}
  };

  function automatic string row_tag(input int i);
    case (i)
      0, 1, 9, 10, 11: return "R2";
      2, 8:            return "R9";
      3, 4, 5, 12, 15, 16, 17: return "R4";
      7:               return "R6";
      13, 19:          return "R8";
      14:              return "R7";
      default:         return "R5";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic rq, input logic [1:0] td,
                      input logic [7:0] no, input logic dv, input logic [2:0] df,
                      input logic mv, input logic [2:0] mf, input logic eg,
                      input logic [2:0] ef, input logic [3:0] ecv,
                      input logic [2:0] ecf, input logic efv, input logic [7:0] efm);
    @(negedge clk);
    fetch_req = rq; fetch_tid = td; fetch_nout = no;
    done_vld = dv; done_frame = df; mis_vld = mv; mis_frame = mf;
    #2;
    check(tag, "fetch_gnt", 32'(fetch_gnt), 32'(eg));
    if (eg) check(tag, "fetch_frame", 32'(fetch_frame), 32'(ef));
    @(posedge clk); #1;
    check(tag, "commit_vld", 32'(commit_vld), 32'(ecv));
    if (ecv[0]) check(tag, "commit_frame0", 32'(commit_frame[2:0]), 32'(ecf));
    check(tag, "flush_vld", 32'(flush_vld), 32'(efv));
    if (efv) check(tag, "flush_mask", 32'(flush_mask), 32'(efm));
  endtask

  task automatic idle_inputs();
    fetch_req = 0; fetch_tid = 0; fetch_nout = 0;
    done_vld = 0; done_frame = 0; mis_vld = 0; mis_frame = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 0; mt_mode = 0;
    #5;
    fetch_req = 1;
    #2;
    check("R1", "gnt in reset", 32'(fetch_gnt), 1);
    check("R1", "frame in reset", 32'(fetch_frame), 0);
    check("R1", "commit in reset", 32'(commit_vld), 0);
    check("R1", "flush in reset", 32'(flush_vld), 0);
    fetch_req = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;

    for (int i = 0; i < 20; i++) begin
      logic [35:0] v;
      v = VEC[i];
      step(row_tag(i), v[35], v[34:33], v[32:25], v[24], v[23:21], v[20],
           v[19:17], v[16], v[15:13], {3'b0, v[12]}, v[11:9], v[8], v[7:0]);
    end

    // single-thread mode: other threads refused (R10), ring fills then stalls (R3)
    step("R10", 1, 2'd1, 8'd1, 0, 0, 0, 0, 0, 0, 4'b0, 0, 0, 0);
    for (int k = 0; k < 7; k++)
      step("R2", 1, 2'd0, 8'd1, 0, 0, 0, 0, 1, 3'((5 + k) % 8), 4'b0, 0, 0, 0);
    step("R3", 1, 2'd0, 8'd1, 0, 0, 0, 0, 0, 0, 4'b0, 0, 0, 0);
    step("R7", 0, 2'd0, 8'd0, 0, 0, 1, 3'd4, 0, 0, 4'b0, 0, 1, 8'hFF);
    step("R7", 1, 2'd0, 8'd1, 0, 0, 0, 0, 1, 3'd4, 4'b0, 0, 0, 0);

    // four-thread mode
    @(negedge clk);
    idle_inputs();
    rst_n = 0; mt_mode = 1;
    @(negedge clk);
    rst_n = 1;
    #2;
    check("R1", "commit after reset", 32'(commit_vld), 0);
    check("R1", "flush after reset", 32'(flush_vld), 0);
    step("R10", 1, 2'd2, 8'd1, 0, 0, 0, 0, 1, 3'd4, 4'b0, 0, 0, 0);
    step("R10", 1, 2'd2, 8'd1, 0, 0, 0, 0, 1, 3'd5, 4'b0, 0, 0, 0);
    step("R3",  1, 2'd2, 8'd1, 0, 0, 0, 0, 0, 0, 4'b0, 0, 0, 0);
    step("R7",  0, 2'd0, 8'd0, 0, 0, 1, 3'd5, 0, 0, 4'b0, 0, 1, 8'h20);
    step("R10", 1, 2'd0, 8'd1, 0, 0, 0, 0, 1, 3'd0, 4'b0, 0, 0, 0);
    step("R10", 1, 2'd0, 8'd1, 0, 0, 0, 0, 1, 3'd1, 4'b0, 0, 0, 0);
    step("R9",  1, 2'd3, 8'd0, 1, 3'd0, 0, 0, 1, 3'd6, 4'b0, 0, 0, 0);
    step("R6",  0, 2'd0, 8'd0, 0, 0, 0, 0, 0, 0, 4'b1001, 3'd0, 0, 0);
    check("R6", "commit_frame3", 32'(commit_frame[11:9]), 6);
    step("R7",  0, 2'd0, 8'd0, 0, 0, 1, 3'd1, 0, 0, 4'b0, 0, 1, 8'h02);
    step("R7",  0, 2'd0, 8'd0, 0, 0, 1, 3'd4, 0, 0, 4'b0, 0, 1, 8'h10);

    @(negedge clk);
    idle_inputs();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule